// File: doc/BRIEF.md
# USB Charger Detection Sequencer

This block steps a port through the charger-identification flow that a USB device runs before it draws more than the default current. It has three phases. First, a contact check on the data lines. Second, a primary comparison that tells a standard host port from a charging port. Third, a secondary comparison that tells a dedicated charger from a charging downstream port. The block drives the enable lines of an analog front end that is not part of this design: a D+ current source, a D- pull-down with separate force-on and force-off controls, a primary/secondary select, a data-line voltage source and a comparator. It reads back a filtered D+ line state and a filtered comparator output.

Every change of the enable lines is followed by a settling wait, counted in pulses of a one-microsecond tick, before the related status input is believed. The D+ status needs a longer wait than the comparator status. The contact debounce repeatedly samples the already-filtered D+ status, once per tick, and requires an unbroken run of high samples. If no contact is seen within a timeout, a flag is raised and the flow still continues. At the end, all sources are shut off and a one-cycle done pulse is issued. The result code is held stable until the next run.

Top module: `usb_chg_detect`

## Requirements
- R1: After reset, and in idle, every control output is low, done is low, result is 0 and the timeout flag is 0. A start pulse is acted on only in idle; a start seen during a run has no effect on its outcome or timing.
- R2: During contact detect, idp_src_en and dm_pd_force_on are high and the other four control outputs are low. dm_pd_force_on and dm_pd_force_off are never high together.
- R3: The D+ status is ignored during the first DP_SETTLE_US ticks of contact detect. A D+ high seen only in that window leads to a timeout.
- R4: Contact is accepted on the DCD_DBNC_US-th consecutive high D+ sample, taken one per tick after the settle window. Any low sample restarts the run.
- R5: If contact is not accepted by the DCD_TIMEOUT_US-th tick of contact detect, dcd_timeout is set to 1 and primary detection still follows. Acceptance on that same tick takes precedence.
- R6: During primary detection, det_secondary is 0; vdat_src_en, cmp_en and dm_pd_force_off are 1; idp_src_en and dm_pd_force_on are 0. cmp_out is sampled once, on the tick after CMP_SETTLE_US settling ticks. Its value before that tick has no effect.
- R7: During secondary detection, det_secondary is 1 and the other control outputs are the same as in primary detection. cmp_out is again sampled once, on the tick after CMP_SETTLE_US settling ticks.
- R8: Result encoding: 1 = standard port (primary low), 2 = charging downstream port (primary high, secondary low), 3 = dedicated charging port (both high). 0 means no result.
- R9: On completion, all control outputs go low and done is high for exactly one cycle. result and dcd_timeout are valid in that cycle and stay unchanged until the next accepted start.
- R10: abort returns the block to idle on the next clock edge. All control outputs go low, no done is given, and result and dcd_timeout are cleared. abort wins over a simultaneous start.
- R11: All timing advances only on cycles where us_tick is high. With us_tick held low, the block stays in its current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a detection run (idle only) |
| abort | input | 1 | Return to idle with all controls off |
| dp_line | input | 1 | Filtered D+ line state |
| cmp_out | input | 1 | Filtered detection comparator output |
| idp_src_en | output | 1 | D+ current source enable |
| dm_pd_force_on | output | 1 | Force D- pull-down active |
| dm_pd_force_off | output | 1 | Force D- pull-down inactive |
| det_secondary | output | 1 | Detection type: 0 primary, 1 secondary |
| vdat_src_en | output | 1 | Data-line voltage source enable |
| cmp_en | output | 1 | Detection comparator enable |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Port type code (R8) |
| dcd_timeout | output | 1 | Contact detect timed out |

## Verification
Take the tick as high every cycle and number the edges from the edge that accepts start, which is edge 1. Contact detect then lasts D edges: DP_SETTLE_US+DCD_DBNC_US for clean contact, DCD_TIMEOUT_US on timeout, and longer by the glitch offset when a low sample breaks the run. Primary detection is visible after edge D+1, secondary after edge D+CMP_SETTLE_US+2, and done after edge 1+D+(CMP_SETTLE_US+1)·k, where k is 1 for a standard port and 2 otherwise. The bench drives dp_line and cmp_out per edge on the falling clock, predicts those edge numbers from the parameters, and samples phase outputs, the done cycle, the result and the flag on the falling edge after the predicted edge.

// File: rtl/usb_chg_detect.sv
module usb_chg_detect #(
  parameter int DP_SETTLE_US   = 560,
  parameter int CMP_SETTLE_US  = 140,
  parameter int DCD_DBNC_US    = 10000,
  parameter int DCD_TIMEOUT_US = 900000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       start,
  input  logic       abort,
  input  logic       dp_line,
  input  logic       cmp_out,
  output logic       idp_src_en,
  output logic       dm_pd_force_on,
  output logic       dm_pd_force_off,
  output logic       det_secondary,
  output logic       vdat_src_en,
  output logic       cmp_en,
  output logic       done,
  output logic [1:0] result,
  output logic       dcd_timeout
);

  localparam int SETTLE_MAX = (DP_SETTLE_US > CMP_SETTLE_US) ? DP_SETTLE_US : CMP_SETTLE_US;
  localparam int SW = $clog2(SETTLE_MAX + 1);
  localparam int DW = $clog2(DCD_DBNC_US + 1);
  localparam int TW = $clog2(DCD_TIMEOUT_US + 1);

  localparam logic [1:0] RES_SDP = 2'd1;
  localparam logic [1:0] RES_CDP = 2'd2;
  localparam logic [1:0] RES_DCP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_DCD, S_PRI, S_SEC, S_FIN} state_t;

  state_t        state;
  logic [SW-1:0] settle_cnt;
  logic [DW-1:0] run_cnt;
  logic [TW-1:0] tmo_cnt;

  logic dp_settled, cmp_settled, contact, tmo_hit;

  assign dp_settled  = settle_cnt == SW'(DP_SETTLE_US);
  assign cmp_settled = settle_cnt == SW'(CMP_SETTLE_US);
  assign contact     = dp_settled && dp_line && (run_cnt == DW'(DCD_DBNC_US - 1));
  assign tmo_hit     = tmo_cnt == TW'(DCD_TIMEOUT_US - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      settle_cnt  <= '0;
      run_cnt     <= '0;
      tmo_cnt     <= '0;
      result      <= '0;
      dcd_timeout <= 1'b0;
    end else if (abort) begin
      state       <= S_IDLE;
      settle_cnt  <= '0;
      run_cnt     <= '0;
      tmo_cnt     <= '0;
      result      <= '0;
      dcd_timeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            state       <= S_DCD;
            settle_cnt  <= '0;
            run_cnt     <= '0;
            tmo_cnt     <= '0;
            result      <= '0;
            dcd_timeout <= 1'b0;
          end
        S_DCD:
          if (us_tick) begin
            tmo_cnt <= tmo_cnt + 1'b1;
            if (!dp_settled) settle_cnt <= settle_cnt + 1'b1;
            else             run_cnt    <= dp_line ? run_cnt + 1'b1 : '0;
            if (contact) begin
              state      <= S_PRI;
              settle_cnt <= '0;
            end else if (tmo_hit) begin
              state       <= S_PRI;
              settle_cnt  <= '0;
              dcd_timeout <= 1'b1;
            end
          end
        S_PRI:
          if (us_tick) begin
            if (!cmp_settled) settle_cnt <= settle_cnt + 1'b1;
            else if (cmp_out) begin
              state      <= S_SEC;
              settle_cnt <= '0;
            end else begin
              state  <= S_FIN;
              result <= RES_SDP;
            end
          end
        S_SEC:
          if (us_tick) begin
            if (!cmp_settled) settle_cnt <= settle_cnt + 1'b1;
            else begin
              state  <= S_FIN;
              result <= cmp_out ? RES_DCP : RES_CDP;
            end
          end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idp_src_en      = state == S_DCD;
  assign dm_pd_force_on  = state == S_DCD;
  assign dm_pd_force_off = (state == S_PRI) || (state == S_SEC);
  assign det_secondary   = state == S_SEC;
  assign vdat_src_en     = (state == S_PRI) || (state == S_SEC);
  assign cmp_en          = (state == S_PRI) || (state == S_SEC);
  assign done            = state == S_FIN;

  // Checker: ticks elapsed since the control outputs last changed
  logic [5:0] ctl, ctl_q;
  int         since_ctl;
  assign ctl = {idp_src_en, dm_pd_force_on, dm_pd_force_off, det_secondary, vdat_src_en, cmp_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      since_ctl <= 0;
    end else begin
      ctl_q     <= ctl;
      since_ctl <= (ctl != ctl_q) ? int'(us_tick) : since_ctl + int'(us_tick);
    end
  end

  a_r2_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_pd_force_on && dm_pd_force_off));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (ctl == 6'd0) && !done && (result == 2'd0) && !dcd_timeout);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start && !abort) |=> $stable(result) && $stable(dcd_timeout));

  a_r6_cmp_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(since_ctl) >= CMP_SETTLE_US);

  a_r3_dp_settle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vdat_src_en) && !dcd_timeout) |-> $past(since_ctl) >= DP_SETTLE_US + DCD_DBNC_US - 1);

endmodule

// File: tb/usb_chg_detect_tb.sv
`timescale 1ns/1ps
module usb_chg_detect_tb;

  localparam int DP   = 6;
  localparam int CMP  = 3;
  localparam int DBNC = 5;
  localparam int TMO  = 20;

  localparam logic [5:0] CTL_DCD = 6'b110000;
  localparam logic [5:0] CTL_PRI = 6'b001011;
  localparam logic [5:0] CTL_SEC = 6'b001111;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b1, start = 1'b0, abort = 1'b0;
  logic dp_line = 1'b0, cmp_out = 1'b0;
  logic idp_src_en, dm_pd_force_on, dm_pd_force_off, det_secondary, vdat_src_en, cmp_en, done, dcd_timeout;
  logic [1:0] result;
  logic [5:0] ctl;
  int errors = 0, checks = 0;

  assign ctl = {idp_src_en, dm_pd_force_on, dm_pd_force_off, det_secondary, vdat_src_en, cmp_en};

  always #2 clk = ~clk;

  usb_chg_detect #(.DP_SETTLE_US(DP), .CMP_SETTLE_US(CMP), .DCD_DBNC_US(DBNC), .DCD_TIMEOUT_US(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .abort(abort),
    .dp_line(dp_line), .cmp_out(cmp_out), .idp_src_en(idp_src_en), .dm_pd_force_on(dm_pd_force_on),
    .dm_pd_force_off(dm_pd_force_off), .det_secondary(det_secondary), .vdat_src_en(vdat_src_en),
    .cmp_en(cmp_en), .done(done), .result(result), .dcd_timeout(dcd_timeout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] dpm;
    logic       pri;
    logic       sec;
    logic [1:0] res;
    logic       tmo;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 1'b0, 1'b0, 2'd1, 1'b0},
    '{2'd1, 1'b1, 1'b0, 2'd2, 1'b0},
    '{2'd1, 1'b1, 1'b1, 2'd3, 1'b0},
    '{2'd0, 1'b0, 1'b0, 2'd1, 1'b1},
    '{2'd0, 1'b1, 1'b1, 2'd3, 1'b1},
    '{2'd0, 1'b1, 1'b0, 2'd2, 1'b1}
  };

  function automatic logic dp_val(input int dpm, input int glitch_e, input int e);
    if (dpm == 1) return logic'(e != glitch_e);
    if (dpm == 2) return logic'(e <= DP + 1);
    return 1'b0;
  endfunction

  // Run a detection with us_tick high every cycle; edge 1 accepts start.
  task automatic run_seq(input int dpm, input int glitch_e, input bit pri, input bit sec,
                         input int kill_e, input int restart_e, input int d,
                         input logic [1:0] exp_res, input bit exp_tmo, input string tag);
    int k, t, sec_first;
    bit early;
    k = (exp_res == 2'd1) ? 1 : 2;
    t = 1 + d + (CMP + 1) * k;
    sec_first = d + CMP + 3;
    early = 1'b0;
    @(negedge clk);
    start   = 1'b1;
    dp_line = dp_val(dpm, glitch_e, 1);
    cmp_out = 1'b0;
    for (int n = 1; n <= t + 1; n++) begin
      @(posedge clk);
      @(negedge clk);
      start   = logic'((n + 1) == restart_e);
      dp_line = dp_val(dpm, glitch_e, n + 1);
      cmp_out = ((n + 1) == kill_e) ? 1'b0 : (((n + 1) < sec_first) ? pri : sec);
      if (n == 1)
        chk(ctl == CTL_DCD, {tag, " R2 contact-detect outputs"}, ctl, CTL_DCD);
      if (n == d + 1)
        chk(ctl == CTL_PRI, {tag, " R6 primary outputs"}, ctl, CTL_PRI);
      if (k == 2 && n == d + CMP + 2)
        chk(ctl == CTL_SEC, {tag, " R7 secondary outputs"}, ctl, CTL_SEC);
      if (n < t && done) early = 1'b1;
      if (n == t) begin
        chk(done == 1'b1, {tag, " R9 done at predicted edge"}, done, 1);
        chk(result == exp_res, {tag, " R8 result code"}, result, exp_res);
        chk(dcd_timeout == exp_tmo, {tag, " R5 timeout flag"}, dcd_timeout, exp_tmo);
        chk(ctl == 6'd0, {tag, " R9 controls off at done"}, ctl, 0);
      end
      if (n == t + 1) begin
        chk(done == 1'b0, {tag, " R9 done is one cycle"}, done, 0);
        chk(result == exp_res, {tag, " R9 result held"}, result, exp_res);
      end
    end
    chk(!early, {tag, " R9 no early done"}, early, 0);
    start = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl == 6'd0, "R1 reset controls", ctl, 0);
    chk(!done && result == 2'd0 && !dcd_timeout, "R1 reset status", {done, result, dcd_timeout}, 0);

    for (int i = 0; i < 6; i++) begin
      int d;
      d = (VECS[i].dpm == 2'd1) ? DP + DBNC : TMO;
      run_seq(int'(VECS[i].dpm), -1, VECS[i].pri, VECS[i].sec, -1, -1, d,
              VECS[i].res, VECS[i].tmo, $sformatf("vec%0d", i));
    end

    // R4: one low sample during the debounce restarts the run
    run_seq(1, DP + 3, 1'b0, 1'b0, -1, -1, DP + 2 + DBNC, 2'd1, 1'b0, "R4 glitch");
    // R3: D+ high only inside the settle window is ignored -> timeout
    run_seq(2, -1, 1'b0, 1'b0, -1, -1, TMO, 2'd1, 1'b1, "R3 early D+");
    // R6: comparator high while settling, low at the sample tick
    run_seq(1, -1, 1'b1, 1'b1, DP + DBNC + CMP + 2, -1, DP + DBNC, 2'd1, 1'b0, "R6 cmp settle");
    // R7: secondary high while settling, low at its sample tick
    run_seq(1, -1, 1'b1, 1'b1, DP + DBNC + 2 * CMP + 3, -1, DP + DBNC, 2'd2, 1'b0, "R7 sec settle");
    // R1: a start pulse in mid-run changes nothing
    run_seq(1, -1, 1'b1, 1'b1, -1, DP + DBNC + 3, DP + DBNC, 2'd3, 1'b0, "R1 restart ignored");

    // R9: result still held many cycles later
    repeat (10) @(negedge clk);
    chk(result == 2'd3, "R9 result held in idle", result, 3);

    // R11: with no ticks the block stays in contact detect
    us_tick = 1'b0;
    dp_line = 1'b1;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(ctl == CTL_DCD, "R11 frozen without tick", ctl, CTL_DCD);
    chk(!done, "R11 no done without tick", done, 0);

    // R10: abort drops everything on the next edge
    us_tick = 1'b1;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(ctl == 6'd0, "R10 abort controls off", ctl, 0);
    chk(result == 2'd0 && !dcd_timeout && !done, "R10 abort status cleared", {done, result, dcd_timeout}, 0);

    // R10: abort with start in the same cycle stays idle
    abort = 1'b1;
    start = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk(ctl == 6'd0, "R10 abort beats start", ctl, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule